// File: doc/BRIEF.md
# Triggered Pixel Line Serializer

This block emits one line of monochrome video at a time. It stays silent until a start-of-visible-line pulse arrives, then drives a fixed number of one-bit pixels. Each pixel is held for a fixed number of system clocks, four by default. When the line is complete it waits for the next pulse. The number of pixels per line is taken once from a configuration input after reset, for example 640 for a common display mode, and is not changed afterwards.

Pixel data arrives as 32-bit words on a valid/ready stream. Each word is spent from its most significant bit down. A word is requested only at a pixel boundary, and only once the previous word is used up. Bits left over at the end of a line carry into the next line, so the stream is a continuous bit sequence. If no word is available when a pixel needs a bit, that pixel is driven low and a sticky underflow flag is raised.

Top module: `pix_line_serializer`

## Requirements
- R1: While reset is active, and on the first cycle after it, `pix_out`, `s_ready` and `underflow` are all 0.
- R2: The pixel count is taken from `cfg_count` on the first cycle after reset in which `cfg_valid` is 1. Any later `cfg_valid` pulse is ignored.
- R3: A `line_start` pulse that arrives before the count has been captured, or when the captured count is zero, starts nothing: `pix_out` stays 0 and no word is accepted.
- R4: When `line_start` is sampled high at an edge while the block is idle, pixel 0 is on `pix_out` from that edge onwards. Exactly N pixels follow, where N is the captured count, and each is held for HOLD (4) clocks.
- R5: Pixels are drawn from each accepted word starting at bit 31 and ending at bit 0.
- R6: `s_ready` is 1 only in a cycle where the next pixel's bit is needed and no unused bit of the current word remains. A word is accepted when `s_valid` and `s_ready` are both 1 at an edge. Unused bits of a word carry over to the next line.
- R7: A `line_start` pulse that arrives while a line is being output is ignored. This includes the last hold cycle of the line. The line still ends after exactly N pixels.
- R8: Outside a line, `pix_out` is 0. Between lines `s_ready` stays 0 unless `line_start` is present, so no word is accepted while idle.
- R9: A pixel that needs a bit when no unused bit remains and `s_valid` is 0 is driven as 0. It sets `underflow`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Offers a pixel count; only the first offer after reset is taken |
| cfg_count | input | 16 | Pixels per line |
| line_start | input | 1 | Start-of-visible-line event, one cycle |
| s_valid | input | 1 | Pixel word available |
| s_data | input | 32 | Pixel word, MSB shown first |
| s_ready | output | 1 | Word accepted at this edge if `s_valid` is 1 |
| pix_out | output | 1 | Serial pixel output |
| underflow | output | 1 | Sticky flag: a pixel was starved of data |

## Verification
The bench uses a 40-pixel line, so lines end partway through a word. A design that drops the leftover bits, or fetches a fresh word on every line, shifts every later pixel out of place. It sends a second configuration offer. A design that accepts that offer and shortens the line fails on a pixel that should be 1.

A start pulse is injected in the middle of a line. A design that restarts on that pulse runs past the expected end, where the output must be low. The last line is starved of data to show that missing bits become low pixels and that the underflow flag stays set through a later well-fed line. A start pulse sent before configuration must leave the output low and the word queue untouched.

// File: rtl/psl_pkg.sv
// Shared types for the pixel line serializer.
// Assumes nothing beyond a standard SystemVerilog package scope.
package psl_pkg;

    typedef enum logic {
        LINE_IDLE = 1'b0,
        LINE_RUN  = 1'b1
    } line_state_t;

endpackage

// File: rtl/psl_cfg_latch.sv
// Captures the pixels-per-line count on the first valid offer after reset.
// Later offers are ignored until the next reset.
// Assumes: cfg_valid is synchronous to clk.
module psl_cfg_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             cfg_ok,
    output logic [CNT_W-1:0] count_q
);

    // One-shot capture of the line length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ok  <= 1'b0;
            count_q <= '0;
        end else if (cfg_valid && !cfg_ok) begin
            cfg_ok  <= 1'b1;
            count_q <= cfg_count;
        end
    end

endmodule

// File: rtl/psl_pixel_timer.sv
// Sequences one line: accepts a start event while idle, then steps through
// `count` pixels of HOLD clocks each. Produces a pulse whenever a new pixel
// bit is due (take_bit) and a pulse on the final edge of the line (line_end).
// Assumes: HOLD >= 2; the count input is stable while a line runs.
module psl_pixel_timer
    import psl_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int HOLD  = 4,
    localparam int PH_W = $clog2(HOLD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             cfg_ok,
    input  logic [CNT_W-1:0] count,
    output logic             running,
    output logic [PH_W-1:0]  phase,
    output logic             take_bit,
    output logic             line_end
);

    line_state_t      st_q;
    logic [CNT_W-1:0] remain_q;
    logic             start_ok;
    logic             last_phase;

    // Decode line start, pixel boundaries and the final edge of the line.
    always_comb begin
        start_ok   = (st_q == LINE_IDLE) && line_start && cfg_ok && (count != '0);
        last_phase = (st_q == LINE_RUN) && (phase == PH_W'(HOLD - 1));
        take_bit   = start_ok || (last_phase && (remain_q != CNT_W'(1)));
        line_end   = last_phase && (remain_q == CNT_W'(1));
        running    = (st_q == LINE_RUN);
    end

    // Line state, hold phase and pixels left, including the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= LINE_IDLE;
            phase    <= '0;
            remain_q <= '0;
        end else begin
            case (st_q)
                LINE_IDLE: begin
                    if (start_ok) begin
                        st_q     <= LINE_RUN;
                        phase    <= '0;
                        remain_q <= count;
                    end
                end
                default: begin
                    if (last_phase) begin
                        phase <= '0;
                        if (remain_q == CNT_W'(1)) begin
                            st_q <= LINE_IDLE;
                        end else begin
                            remain_q <= remain_q - CNT_W'(1);
                        end
                    end else begin
                        phase <= phase + PH_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/psl_word_unpacker.sv
// Holds the current pixel word and hands out its bits MSB first, one per
// take_bit pulse. Requests a new word from the stream only when take_bit
// is high and no unused bit remains. Reports bit_ok = 0 when starved.
// Assumes: take_bit is a single-cycle pulse per pixel.
module psl_word_unpacker #(
    parameter int WORD_W = 32,
    localparam int LEFT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_bit,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    output logic              bit_val,
    output logic              bit_ok,
    output logic [LEFT_W-1:0] bits_left
);

    logic [WORD_W-1:0] shreg_q;
    logic              have_bit;

    // Choose the next bit from the held word, or from the stream word on offer.
    always_comb begin
        have_bit = (bits_left != '0);
        s_ready  = take_bit && !have_bit;
        bit_ok   = have_bit || s_valid;
        bit_val  = have_bit ? shreg_q[WORD_W-1] : s_data[WORD_W-1];
    end

    // Shift the held word, or load a fresh one, as each bit is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bits_left <= '0;
        end else if (take_bit) begin
            if (have_bit) begin
                shreg_q   <= shreg_q << 1;
                bits_left <= bits_left - LEFT_W'(1);
            end else if (s_valid) begin
                shreg_q   <= s_data << 1;
                bits_left <= LEFT_W'(WORD_W - 1);
            end
        end
    end

endmodule

// File: rtl/pix_line_serializer.sv
// Top level: a triggered, count-bounded serializer of one-bit pixels.
// Ties together the configuration latch, the pixel timer and the word
// unpacker, and registers the serial output and the sticky underflow flag.
// Assumes: line_start and all stream inputs are synchronous to clk.
module pix_line_serializer #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    parameter int HOLD   = 4,
    localparam int PH_W   = $clog2(HOLD),
    localparam int LEFT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              line_start,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    output logic              s_ready,
    output logic              pix_out,
    output logic              underflow
);

    logic              cfg_ok;
    logic [CNT_W-1:0]  count_q;
    logic              running;
    logic [PH_W-1:0]   phase;
    logic              take_bit;
    logic              line_end;
    logic              bit_val;
    logic              bit_ok;
    logic [LEFT_W-1:0] bits_left;

    psl_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_count (cfg_count),
        .cfg_ok    (cfg_ok),
        .count_q   (count_q)
    );

    psl_pixel_timer #(.CNT_W(CNT_W), .HOLD(HOLD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .cfg_ok     (cfg_ok),
        .count      (count_q),
        .running    (running),
        .phase      (phase),
        .take_bit   (take_bit),
        .line_end   (line_end)
    );

    psl_word_unpacker #(.WORD_W(WORD_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_bit  (take_bit),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .bit_val   (bit_val),
        .bit_ok    (bit_ok),
        .bits_left (bits_left)
    );

    // Serial output register: new bit at each pixel boundary, low after the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out <= 1'b0;
        end else if (take_bit) begin
            pix_out <= bit_ok & bit_val;
        end else if (line_end) begin
            pix_out <= 1'b0;
        end
    end

    // Sticky starvation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else if (take_bit && !bit_ok) begin
            underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/psl_checker.sv
// Temporal checks for pix_line_serializer, bound into every instance.
// Assumes: the observed signals come from the bound top-level scope.
module psl_checker #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    parameter int HOLD   = 4,
    localparam int PH_W   = $clog2(HOLD),
    localparam int LEFT_W = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              s_valid,
    input logic              s_ready,
    input logic              pix_out,
    input logic              underflow,
    input logic              running,
    input logic [PH_W-1:0]   phase,
    input logic [LEFT_W-1:0] bits_left,
    input logic              cfg_ok,
    input logic [CNT_W-1:0]  count_q
);

    // R2: the captured count never changes once captured
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |=> (cfg_ok && $stable(count_q)));

    // R4: a pixel holds its value for the remaining clocks of its phase
    assert_pixel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase != '0) |-> $stable(pix_out));

    // R6: an accepted word leaves all but its first bit unused
    assert_word_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (bits_left == LEFT_W'(WORD_W - 1)));

    // R8: the output is low outside a line
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pix_out);

    // R8: no word is requested while idle without a start event
    assert_idle_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !line_start) |-> !s_ready);

    // R9: underflow stays set once raised
    assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

endmodule

bind pix_line_serializer psl_checker #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W),
    .HOLD   (HOLD)
) u_psl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .pix_out    (pix_out),
    .underflow  (underflow),
    .running    (running),
    .phase      (phase),
    .bits_left  (bits_left),
    .cfg_ok     (cfg_ok),
    .count_q    (count_q)
);

// File: tb/tb_pix_line_serializer.sv
// Scoreboard bench: push_word queues stream words and their expected bits,
// the line monitor pops expected bits and compares them pixel by pixel.
module tb_pix_line_serializer;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int HOLD   = 4;
    localparam int LINE_N = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_valid = 1'b0;
    logic [CNT_W-1:0]  cfg_count = '0;
    logic              line_start = 1'b0;
    logic              s_valid = 1'b0;
    logic [WORD_W-1:0] s_data = '0;
    logic              s_ready;
    logic              pix_out;
    logic              underflow;

    int checks = 0;
    int errors = 0;
    logic [WORD_W-1:0] wq[$];
    bit                exp_q[$];
    logic              hs = 1'b0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    pix_line_serializer #(.WORD_W(WORD_W), .CNT_W(CNT_W), .HOLD(HOLD)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_count  (cfg_count),
        .line_start (line_start),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .pix_out    (pix_out),
        .underflow  (underflow)
    );

    task automatic check_bit(string req, string what, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, expv);
        end
    endtask

    task automatic check_int(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic void refresh();
        s_valid = (wq.size() != 0);
        s_data  = s_valid ? wq[0] : '0;
    endfunction

    // Driver: queue a stream word and its pixels, MSB first.
    task automatic push_word(logic [WORD_W-1:0] w);
        wq.push_back(w);
        for (int b = WORD_W - 1; b >= 0; b--) exp_q.push_back(w[b]);
        refresh();
    endtask

    // Record handshakes at the edge; retire the word off the edge.
    always @(posedge clk) hs <= s_valid && s_ready;
    always @(negedge clk) begin
        if (hs) begin
            void'(wq.pop_front());
            refresh();
        end
    end

    // Monitor one line; call at a negedge. inject_at >= 0 pulses a start mid-line.
    task automatic run_line(int n, int inject_at, string tag);
        logic expb;
        expb = 1'b0;
        line_start = 1'b1;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < HOLD; k++) begin
                @(negedge clk);
                if (i == 0 && k == 0) line_start = 1'b0;
                if (i == inject_at && k == 0) line_start = 1'b1;
                if (i == inject_at && k == 1) line_start = 1'b0;
                if (k == 0) expb = (exp_q.size() != 0) ? exp_q.pop_front() : 1'b0;
                check_bit(tag, $sformatf("pixel %0d clk %0d", i, k), pix_out, expb);
            end
        end
        // R8: after the last pixel the output drops and stays low
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            check_bit("R8", $sformatf("idle after line %0d", j), pix_out, 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit("R1", "pix_out in reset", pix_out, 1'b0);
        check_bit("R1", "s_ready in reset", s_ready, 1'b0);
        check_bit("R1", "underflow in reset", underflow, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", "pix_out after reset", pix_out, 1'b0);
        check_bit("R1", "underflow after reset", underflow, 1'b0);

        push_word(32'hA5C3_0F1E);
        push_word(32'h8000_0001);
        push_word(32'hFFFF_0000);
        push_word(32'h1234_5678);
        check_bit("R8", "no request while idle", s_ready, 1'b0);

        // R3: start before configuration does nothing
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            check_bit("R3", "pix_out unconfigured", pix_out, 1'b0);
        end
        check_int("R3", "words left unconfigured", wq.size(), 4);

        // R2: first offer taken, second ignored
        cfg_valid = 1'b1;
        cfg_count = CNT_W'(LINE_N);
        @(negedge clk);
        cfg_count = CNT_W'(8);
        @(negedge clk);
        cfg_valid = 1'b0;
        @(negedge clk);

        // R4/R5/R2: a 40-pixel line; leftover bits carry over (R6)
        run_line(LINE_N, -1, "R2/R4/R5");
        check_int("R6", "words left after line 1", wq.size(), 2);
        repeat (5) @(negedge clk);
        check_int("R8", "no idle consumption", wq.size(), 2);

        // R7: mid-line start ignored
        run_line(LINE_N, 5, "R7");
        check_int("R6", "words left after line 2", wq.size(), 1);

        run_line(LINE_N, -1, "R6");
        check_int("R6", "words left after line 3", wq.size(), 0);
        check_bit("R9", "no underflow yet", underflow, 1'b0);

        // R9: 8 buffered bits remain, the other 32 pixels starve low
        run_line(LINE_N, -1, "R9");
        check_bit("R9", "underflow raised", underflow, 1'b1);

        // R9: flag stays set through a fully fed line
        push_word(32'hC0DE_F00D);
        push_word(32'h5A5A_A5A5);
        run_line(LINE_N, -1, "R9");
        check_bit("R9", "underflow sticky", underflow, 1'b1);

        done = 1'b1;
        finish_run();
    end

endmodule